// File: doc/BRIEF.md
# Serial Packet Bridge for DSP Core Ports

This block connects a bank of DSP core serial links to a byte-wide host register bus. Each link has a receive path and a transmit path. On the receive path, the core drives a serial clock, a frame-sync strobe and a data line. The bridge turns each framed 8-bit word into a byte and stores it in that link's own buffer. It raises the link's ready bit once the programmed number of bytes has arrived. The host then drains the buffer one byte per read of the link's data register.

On the transmit path, a host write of one byte starts a serial frame toward the core. The bridge generates the serial clock and the frame-sync itself. The link's transmit status bit tells the host when the next byte may be written.

Each receive lane has two named states. `RX_IDLE` waits for a sampled serial-clock rise with frame-sync high, which is the `start` transition to `RX_SHIFT`. `RX_SHIFT` collects bits. It goes back to `RX_IDLE` on the eighth bit (`byte_done`), or stays in `RX_SHIFT` and restarts its bit count when frame-sync appears again (`resync`).

Each transmit lane has three named states:
- `TX_IDLE` moves to `TX_LOW` when a byte is accepted (`accept`).
- `TX_LOW` holds the serial clock low for CLK_DIV cycles, then moves to `TX_HIGH` (`rise`).
- `TX_HIGH` holds the serial clock high for CLK_DIV cycles. It then goes to `TX_LOW` for the next bit (`next_bit`), or to `TX_IDLE` after the last bit (`frame_end`).

Top module: `dsp_sport_bridge`

## Requirements
- R1: After reset, the receive status register (address 0x00) reads 0, the transmit status register (address 0x01) reads all ones for the implemented ports, and every data register reads 0.
- R2: A receive word starts on the serial-clock rise that samples frame-sync high. That bit is the MSB, and the next seven rises supply the remaining bits, MSB first. The complete byte is stored in that port's buffer.
- R3: The receive status bit of port p (bit p of address 0x00) rises only when the stored byte count reaches that port's nonzero packet size. The count then restarts for the next packet.
- R4: The host reading port p's data register clears port p's receive status bit. The remaining bytes of the packet stay readable.
- R5: Each read of data register 0x08+p returns the oldest unread byte and advances the port's read pointer. A read of an empty buffer returns the last byte read (0 after reset) and moves nothing.
- R6: A write to packet size register 0x10+p clears port p's receive status bit and restarts its byte count from zero.
- R7: A byte that completes while the buffer already holds DEPTH unread bytes is dropped. The drop clears the port's receive status bit and restarts its count. The buffer never holds more than DEPTH bytes.
- R8: A host write to data register 0x08+p while transmit status bit p (address 0x01) is 1 starts a frame. The frame sends 8 bits, MSB first. Each bit is held with the serial clock low for CLK_DIV cycles and then high for CLK_DIV cycles. Frame-sync is high for the first bit only. The status bit reads 0 until the frame ends.
- R9: A write to a transmit data register while its frame is in progress is ignored: no extra frame is produced.
- R10: When a port's packet completes in the same cycle that the host reads that port's data register, the receive status bit ends up set.
- R11: Reads from addresses outside 0x00, 0x01, 0x08+p and 0x10+p return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| rx_sclk | input | NPORT | Receive serial clock per port, from the core |
| rx_fs | input | NPORT | Receive frame-sync per port |
| rx_sd | input | NPORT | Receive serial data per port |
| tx_sclk | output | NPORT | Transmit serial clock per port |
| tx_fs | output | NPORT | Transmit frame-sync per port |
| tx_sd | output | NPORT | Transmit serial data per port |

## Verification
The host read that clears a port's ready bit can land in the same clock edge where the last byte of the next packet is stored. Two outcomes then compete: the read's clear and the packet's set. The bench provokes this by fixing the packet size at two and leaving one byte unread. It sends two more bytes and issues a data read exactly one clock after the final serial-clock rise, which is the edge where that byte is written. The read must return the older byte, and the status register must show the ready bit still set afterwards.

// File: rtl/sport_pkg.sv
package sport_pkg;
    typedef enum logic {RX_IDLE, RX_SHIFT} rx_state_t;
    typedef enum logic [1:0] {TX_IDLE, TX_LOW, TX_HIGH} tx_state_t;

    localparam logic [7:0] ADDR_RX_STAT = 8'h00;
    localparam logic [7:0] ADDR_TX_STAT = 8'h01;
    localparam logic [7:0] ADDR_DATA    = 8'h08;
    localparam logic [7:0] ADDR_SIZE    = 8'h10;
endpackage

// File: rtl/sport_rx_lane.sv
module sport_rx_lane
    import sport_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        fs,
    input  logic        sd,
    input  logic        size_wr,
    input  logic [7:0]  size_val,
    input  logic        rd_pop,
    output logic [7:0]  rd_byte,
    output logic        rdy,
    output logic        store,
    output logic [AW:0] fill
);
    rx_state_t st, st_nx;
    logic       sclk_q, rise;
    logic [2:0] nbit;
    logic [7:0] sr, byte_q;
    logic       byte_vld;

    logic [7:0]  mem [DEPTH];
    logic [AW:0] wp, rp;
    logic [7:0]  last, pkt_size, cnt;
    logic        empty, full, pop, push, ovf, done;

    assign rise = sclk & ~sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_IDLE;
        else        st <= st_nx;
    end

    // transitions: start, byte_done, resync
    always_comb begin
        st_nx = st;
        unique case (st)
            RX_IDLE:  if (rise && fs) st_nx = RX_SHIFT;
            RX_SHIFT: if (rise && !fs && nbit == 3'd7) st_nx = RX_IDLE;
            default:  st_nx = RX_IDLE;
        endcase
    end

    // shift datapath and byte output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            nbit     <= '0;
            sr       <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            byte_vld <= 1'b0;
            if (rise) begin
                if (fs) begin
                    sr   <= {7'b0, sd};
                    nbit <= 3'd1;
                end else if (st == RX_SHIFT) begin
                    sr   <= {sr[6:0], sd};
                    nbit <= nbit + 3'd1;
                    if (nbit == 3'd7) begin
                        byte_vld <= 1'b1;
                        byte_q   <= {sr[6:0], sd};
                    end
                end
            end
        end
    end

    assign fill  = wp - rp;
    assign empty = (wp == rp);
    assign full  = (fill == (AW+1)'(DEPTH));
    assign pop   = rd_pop && !empty;
    assign push  = byte_vld && (!full || pop);
    assign ovf   = byte_vld && !push;
    assign done  = push && (pkt_size != 8'd0) && (({1'b0, cnt} + 9'd1) >= {1'b0, pkt_size});
    assign store = push;
    assign rd_byte = empty ? last : mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            last     <= '0;
            pkt_size <= '0;
            cnt      <= '0;
            rdy      <= 1'b0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop) begin
                last <= mem[rp[AW-1:0]];
                rp   <= rp + 1'b1;
            end
            if (size_wr) pkt_size <= size_val;
            if (size_wr || ovf) begin
                cnt <= '0;
                rdy <= 1'b0;
            end else begin
                if (push) cnt <= done ? 8'd0 : cnt + 8'd1;
                if (done)        rdy <= 1'b1;   // packet set wins over read clear
                else if (rd_pop) rdy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sport_tx_lane.sv
module sport_tx_lane
    import sport_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DW = $clog2(CLK_DIV) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       sclk,
    output logic       fs,
    output logic       sd
);
    tx_state_t st, st_nx;
    logic [7:0]    sr;
    logic [2:0]    bi;
    logic [DW-1:0] dc;
    logic          half_end;

    assign half_end = (dc == DW'(CLK_DIV - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    // transitions: accept, rise, next_bit, frame_end
    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (wr) st_nx = TX_LOW;
            TX_LOW:  if (half_end) st_nx = TX_HIGH;
            TX_HIGH: if (half_end) st_nx = (bi == 3'd0) ? TX_IDLE : TX_LOW;
            default: st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
            bi <= '0;
            dc <= '0;
        end else if (st == TX_IDLE) begin
            dc <= '0;
            if (wr) begin
                sr <= wdata;
                bi <= 3'd7;
            end
        end else begin
            dc <= half_end ? '0 : dc + 1'b1;
            if (st == TX_HIGH && half_end) begin
                sr <= {sr[6:0], 1'b0};
                bi <= bi - 3'd1;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (st != TX_IDLE);
        sclk = (st == TX_HIGH);
        sd   = busy & sr[7];
        fs   = busy & (bi == 3'd7);
    end
endmodule

// File: rtl/dsp_sport_bridge.sv
module dsp_sport_bridge
    import sport_pkg::*;
#(
    parameter int NPORT   = 8,
    parameter int DEPTH   = 16,
    parameter int CLK_DIV = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [NPORT-1:0] rx_sclk,
    input  logic [NPORT-1:0] rx_fs,
    input  logic [NPORT-1:0] rx_sd,
    output logic [NPORT-1:0] tx_sclk,
    output logic [NPORT-1:0] tx_fs,
    output logic [NPORT-1:0] tx_sd
);
    logic [NPORT-1:0]        rx_rdy, rx_store, tx_busy;
    logic [NPORT*(AW+1)-1:0] rx_fill_flat;
    logic [7:0]              rx_byte [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        logic hit_data, hit_size;
        assign hit_data = (bus_addr == 8'(ADDR_DATA + 8'(p)));
        assign hit_size = (bus_addr == 8'(ADDR_SIZE + 8'(p)));

        sport_rx_lane #(.DEPTH(DEPTH)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .sclk     (rx_sclk[p]),
            .fs       (rx_fs[p]),
            .sd       (rx_sd[p]),
            .size_wr  (bus_wr && hit_size),
            .size_val (bus_wdata),
            .rd_pop   (bus_rd && hit_data),
            .rd_byte  (rx_byte[p]),
            .rdy      (rx_rdy[p]),
            .store    (rx_store[p]),
            .fill     (rx_fill_flat[p*(AW+1) +: AW+1])
        );

        sport_tx_lane #(.CLK_DIV(CLK_DIV)) u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_wr && hit_data),
            .wdata (bus_wdata),
            .busy  (tx_busy[p]),
            .sclk  (tx_sclk[p]),
            .fs    (tx_fs[p]),
            .sd    (tx_sd[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_RX_STAT) bus_rdata = 8'(rx_rdy);
        if (bus_addr == ADDR_TX_STAT) bus_rdata = 8'(~tx_busy);
        for (int p = 0; p < NPORT; p++) begin
            if (bus_addr == 8'(ADDR_DATA + 8'(p))) bus_rdata = rx_byte[p];
        end
    end
endmodule

// File: rtl/sport_bridge_chk.sv
module sport_bridge_chk
    import sport_pkg::*;
#(
    parameter int NPORT = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [7:0]              bus_addr,
    input logic                    bus_wr,
    input logic [NPORT-1:0]        tx_sclk,
    input logic [NPORT-1:0]        tx_sd,
    input logic [NPORT-1:0]        rx_rdy,
    input logic [NPORT-1:0]        rx_store,
    input logic [NPORT-1:0]        tx_busy,
    input logic [NPORT*(AW+1)-1:0] rx_fill_flat
);
    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        AST_SIZE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == 8'(ADDR_SIZE + 8'(p))) |=> !rx_rdy[p]);   // R6
        AST_READY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rx_rdy[p]) |-> $past(rx_store[p]));                        // R3
        AST_TX_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tx_busy[p]) |-> $past(bus_wr && bus_addr == 8'(ADDR_DATA + 8'(p)))); // R8
        AST_TX_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tx_sclk[p]) |-> $stable(tx_sd[p]));                        // R8
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            rx_fill_flat[p*(AW+1) +: AW+1] <= (AW+1)'(DEPTH));               // R7
    end
endmodule

bind dsp_sport_bridge sport_bridge_chk #(.NPORT(NPORT), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .tx_sclk      (tx_sclk),
    .tx_sd        (tx_sd),
    .rx_rdy       (rx_rdy),
    .rx_store     (rx_store),
    .tx_busy      (tx_busy),
    .rx_fill_flat (rx_fill_flat)
);

// File: tb/dsp_sport_bridge_tb.sv
module dsp_sport_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 8;
    localparam int DEPTH = 16;
    localparam int CLK_DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [NPORT-1:0] rx_sclk = '0, rx_fs = '0, rx_sd = '0;
    logic [NPORT-1:0] tx_sclk, tx_fs, tx_sd;

    int checks = 0, fails = 0;
    logic [7:0] rx_exp[$];
    logic [7:0] tx_exp[$];
    int frames = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_sport_bridge #(.NPORT(NPORT), .DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_sclk(rx_sclk), .rx_fs(rx_fs),
        .rx_sd(rx_sd), .tx_sclk(tx_sclk), .tx_fs(tx_fs), .tx_sd(tx_sd));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_read(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: serial byte into a port, expected byte pushed to the scoreboard
    task automatic send_rx(int p, logic [7:0] b, bit keep, bit collide,
                           output logic [7:0] col_data);
        col_data = '0;
        if (keep) rx_exp.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            rx_sd[p] = b[i]; rx_fs[p] = (i == 7); rx_sclk[p] = 1'b0;
            repeat (2) @(negedge clk);
            rx_sclk[p] = 1'b1;
            if (i == 0 && collide) begin
                @(negedge clk);
                bus_addr = 8'h08 + 8'(p); bus_rd = 1'b1;
                #1 col_data = bus_rdata;
                @(negedge clk);
                bus_rd = 1'b0;
            end else begin
                repeat (2) @(negedge clk);
            end
        end
        rx_sclk[p] = 1'b0; rx_fs[p] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // reads one byte of port p and compares with the scoreboard
    task automatic pop_rx(int p, string req);
        logic [7:0] d;
        host_read(8'h08 + 8'(p), d);
        if (rx_exp.size() == 0) chk({req, " unexpected data"}, 1, 0);
        else chk(req, d, rx_exp.pop_front());
    endtask

    // monitor: rebuilds transmit frames of port mon_p, compares with the scoreboard
    int mon_p = 5;
    logic prev_sclk = 1'b0;
    int nbits = 0, since = 0;
    logic [7:0] shv = '0;
    always @(negedge clk) begin
        since++;
        if (rst_n && tx_sclk[mon_p] && !prev_sclk) begin
            if (tx_fs[mon_p]) begin
                nbits = 1; shv = {7'b0, tx_sd[mon_p]};
            end else if (nbits > 0) begin
                chk("R8 bit period", since, 2*CLK_DIV);
                nbits++; shv = {shv[6:0], tx_sd[mon_p]};
            end
            since = 0;
            if (nbits == 8) begin
                nbits = 0; frames++;
                if (tx_exp.size() == 0) chk("R9 extra frame", 1, 0);
                else chk("R8 serial byte", shv, tx_exp.pop_front());
            end
        end
        prev_sclk = tx_sclk[mon_p];
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, cd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        host_read(8'h00, d); chk("R1 rx status", d, 8'h00);
        host_read(8'h01, d); chk("R1 tx status", d, 8'hFF);
        host_read(8'h08, d); chk("R1 data reg", d, 8'h00);
        // R11 unmapped
        host_read(8'h30, d); chk("R11 unmapped", d, 8'h00);

        // R2 R3 packet of three on port 0
        host_write(8'h10, 8'd3);
        send_rx(0, 8'hA5, 1, 0, cd);
        send_rx(0, 8'h3C, 1, 0, cd);
        host_read(8'h00, d); chk("R3 not ready early", d, 8'h00);
        send_rx(0, 8'h81, 1, 0, cd);
        host_read(8'h00, d); chk("R3 ready on count", d, 8'h01);
        pop_rx(0, "R2 first byte");
        host_read(8'h00, d); chk("R4 cleared on read", d, 8'h00);
        pop_rx(0, "R5 second byte");
        pop_rx(0, "R5 third byte");
        host_read(8'h08, d); chk("R5 empty read holds", d, 8'h81);
        send_rx(0, 8'h11, 1, 0, cd);
        pop_rx(0, "R5 pointer not moved");

        // R6 size write restarts count and clears ready
        host_write(8'h10, 8'd2);
        send_rx(0, 8'h22, 1, 0, cd);
        host_read(8'h00, d); chk("R6 count restarted", d, 8'h00);
        send_rx(0, 8'h33, 1, 0, cd);
        host_read(8'h00, d); chk("R3 ready size two", d, 8'h01);
        host_write(8'h10, 8'd2);
        host_read(8'h00, d); chk("R6 size write clears", d, 8'h00);
        pop_rx(0, "R6 data kept");
        pop_rx(0, "R6 data kept");

        // R10 packet completion collides with read on port 1
        host_write(8'h11, 8'd2);
        send_rx(1, 8'h44, 1, 0, cd);
        send_rx(1, 8'h55, 1, 0, cd);
        host_read(8'h00, d); chk("R3 port1 ready", d, 8'h02);
        pop_rx(1, "R5 port1 byte");
        host_read(8'h00, d); chk("R4 port1 cleared", d, 8'h00);
        send_rx(1, 8'h66, 0, 0, cd);
        send_rx(1, 8'h77, 0, 1, cd);
        chk("R10 collide read data", cd, rx_exp.pop_front());
        rx_exp.push_back(8'h66); rx_exp.push_back(8'h77);
        host_read(8'h00, d); chk("R10 set wins", d, 8'h02);
        pop_rx(1, "R10 next byte");
        pop_rx(1, "R10 last byte");

        // R7 overflow on port 2
        host_write(8'h12, 8'd8);
        for (int k = 0; k < DEPTH; k++) send_rx(2, 8'(8'h80 + k), 1, 0, cd);
        host_read(8'h00, d); chk("R7 ready before overflow", d, 8'h04);
        send_rx(2, 8'hEE, 0, 0, cd);
        host_read(8'h00, d); chk("R7 overflow clears", d, 8'h00);
        for (int k = 0; k < DEPTH; k++) pop_rx(2, "R7 buffer content");
        host_read(8'h0A, d); chk("R7 dropped byte absent", d, 8'h8F);

        // R8 R9 transmit on port 5
        tx_exp.push_back(8'hC3);
        host_write(8'h0D, 8'hC3);
        host_write(8'h0D, 8'h5A);
        host_read(8'h01, d); chk("R8 busy status", d, 8'hDF);
        for (int k = 0; k < 200 && d != 8'hFF; k++) host_read(8'h01, d);
        chk("R8 ready after frame", d, 8'hFF);
        tx_exp.push_back(8'h96);
        host_write(8'h0D, 8'h96);
        d = '0;
        for (int k = 0; k < 200 && d != 8'hFF; k++) host_read(8'h01, d);
        repeat (10) @(negedge clk);
        chk("R9 frame count", frames, 2);
        chk("R8 scoreboard drained", tx_exp.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule